// File: doc/BRIEF.md
# Pipelined Inner-Product Accumulator

This block computes the dot product of two signed integer vectors that arrive one element pair per clock. Every accepted pair goes through a four-segment multiplier pipeline. The products then enter a four-segment adder whose output is fed back to its own input. The adder takes four cycles per pass, so four partial sums are in flight in the loop at any time. Each new product joins the partial sum that left the adder four cycles earlier. The loop therefore never stalls waiting for an adder result.

The source marks the final pair of a vector with a last flag. Once that pair is accepted, the block stops taking input until the vector has been closed. It waits for the last product to enter the loop. It then folds the four partial sums through a two-level adder tree and publishes the total with a one-cycle done pulse. While it folds, it clears the loop so that the next vector starts from zero. Idle cycles inside a vector are allowed. A vector may have any length of one or more, including lengths that are not a multiple of four. Slots that receive no product stay at zero.

Top module: `dp_inner_product`

## Requirements
- R1: The published result equals the sum over the vector of in_a times in_b, with both read as signed two's complement. The sum is taken modulo 2^ACC_W.
- R2: out_done is high for exactly one cycle per vector. out_sum changes only in the cycle where out_done rises, and it holds its value until the next vector completes.
- R3: out_done goes high after the (MUL_STAGES+2)th rising edge that follows the edge accepting the element flagged last. With the defaults this is the 6th edge. out_done stays low in every cycle before that.
- R4: Each vector starts from zero partial sums, so a vector's result does not depend on any earlier vector.
- R5: The result is correct for vector lengths of 1, 2, 3 and other values that are not a multiple of four.
- R6: Cycles with in_valid low inside a vector leave the result unchanged.
- R7: A pair presented after the last element has been accepted and before out_done is ignored. A new vector may begin with a pair presented in the same cycle in which out_done is high.
- R8: After reset, out_done is low and out_sum is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An element pair is presented this cycle |
| in_last | input | 1 | The presented pair is the final one of its vector |
| in_a | input | DATA_W | Element of the first vector, signed |
| in_b | input | DATA_W | Element of the second vector, signed |
| out_done | output | 1 | One-cycle pulse marking a new result |
| out_sum | output | ACC_W | Dot product of the most recent completed vector |

## Verification
The bench sends vectors of length 1, 2, 3, 5 and 7. A design that only closes full groups of four would drop or duplicate the products in the unused slots of such vectors. It sends a vector of large negative pairs followed by an all-zero vector. If the loop were not cleared during the fold, the second result would come out nonzero. It holds in_valid high with junk during the drain window and then starts the next vector in the done cycle. An accept gate that opens early would add the junk to one of the two results, and one that opens late would drop the first pair of the next vector. Random vectors with idle gaps, and the exact cycle count to done, expose slot misalignment and any off-by-one in the flush control.

// File: rtl/dp_pkg.sv
package dp_pkg;

    localparam int DP_DATA_W     = 8;
    localparam int DP_ACC_W      = 24;
    localparam int DP_MUL_STAGES = 4;
    localparam int DP_ADD_STAGES = 4;

    // Control phase of the accumulator.
    typedef enum logic [1:0] {
        PH_ACCEPT = 2'd0,
        PH_FLUSH  = 2'd1,
        PH_PAIR   = 2'd2,
        PH_FINAL  = 2'd3
    } phase_e;

    // Side-band tag carried alongside each product.
    typedef struct packed {
        logic vld;
        logic last;
    } tag_t;

    function automatic logic phase_busy(phase_e p);
        return p != PH_ACCEPT;
    endfunction

endpackage

// File: rtl/dp_mul_pipe.sv
module dp_mul_pipe
    import dp_pkg::*;
#(
    parameter int DATA_W = DP_DATA_W,
    parameter int ACC_W  = DP_ACC_W,
    parameter int STAGES = DP_MUL_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_fire,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_vld,
    output logic              out_last,
    output logic [ACC_W-1:0]  out_prod
);
    localparam int PROD_W = 2 * DATA_W;

    tag_t             tag_q  [STAGES];
    logic [ACC_W-1:0] prod_q [STAGES];

    logic signed [PROD_W-1:0] raw_prod;
    assign raw_prod = $signed(in_a) * $signed(in_b);

    // Segment 0 forms the product; the others match latency.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                tag_q[s]  <= '0;
                prod_q[s] <= '0;
            end
        end else begin
            tag_q[0].vld  <= in_fire;
            tag_q[0].last <= in_fire & in_last;
            prod_q[0]     <= in_fire ? ACC_W'(raw_prod) : '0;
            for (int s = 1; s < STAGES; s++) begin
                tag_q[s]  <= tag_q[s-1];
                prod_q[s] <= prod_q[s-1];
            end
        end
    end

    assign out_vld  = tag_q[STAGES-1].vld;
    assign out_last = tag_q[STAGES-1].last;
    assign out_prod = prod_q[STAGES-1];

endmodule

// File: rtl/dp_add_ring.sv
module dp_add_ring
    import dp_pkg::*;
#(
    parameter int ACC_W = DP_ACC_W,
    parameter int SLOTS = DP_ADD_STAGES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   add_vld,
    input  logic [ACC_W-1:0]       add_val,
    output logic [SLOTS*ACC_W-1:0] slots_flat
);
    logic [ACC_W-1:0] seg_q [SLOTS];
    logic [ACC_W-1:0] addend;

    assign addend = add_vld ? add_val : '0;

    // The sum leaving the last segment is recombined with the new product.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int s = 0; s < SLOTS; s++) seg_q[s] <= '0;
        end else begin
            seg_q[0] <= seg_q[SLOTS-1] + addend;
            for (int s = 1; s < SLOTS; s++) seg_q[s] <= seg_q[s-1];
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_flat
        assign slots_flat[g*ACC_W +: ACC_W] = seg_q[g];
    end

endmodule

// File: rtl/dp_fold.sv
module dp_fold
    import dp_pkg::*;
#(
    parameter int ACC_W = DP_ACC_W,
    parameter int SLOTS = DP_ADD_STAGES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cap_pairs,
    input  logic                   cap_final,
    input  logic [SLOTS*ACC_W-1:0] slots_flat,
    output logic [ACC_W-1:0]       result
);
    localparam int PAIRS = SLOTS / 2;

    logic [PAIRS*ACC_W-1:0] pair_flat;
    logic [ACC_W-1:0]       total;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic [ACC_W-1:0] pair_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pair_q <= '0;
            end else if (cap_pairs) begin
                pair_q <= slots_flat[(2*p)*ACC_W +: ACC_W]
                        + slots_flat[(2*p+1)*ACC_W +: ACC_W];
            end
        end
        assign pair_flat[p*ACC_W +: ACC_W] = pair_q;
    end

    always_comb begin
        total = '0;
        for (int p = 0; p < PAIRS; p++) total = total + pair_flat[p*ACC_W +: ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (cap_final) begin
            result <= total;
        end
    end

endmodule

// File: rtl/dp_inner_product.sv
module dp_inner_product
    import dp_pkg::*;
#(
    parameter int DATA_W     = DP_DATA_W,
    parameter int ACC_W      = DP_ACC_W,
    parameter int MUL_STAGES = DP_MUL_STAGES,
    parameter int ADD_STAGES = DP_ADD_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_done,
    output logic [ACC_W-1:0]  out_sum
);
    phase_e phase_q;
    logic   busy;
    logic   in_fire;
    logic   mul_vld;
    logic   mul_last;
    logic   done_q;
    logic [ACC_W-1:0]            mul_prod;
    logic [ADD_STAGES*ACC_W-1:0] ring_flat;

    assign busy    = phase_busy(phase_q);
    assign in_fire = in_valid & ~busy;

    dp_mul_pipe #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .STAGES (MUL_STAGES)
    ) u_mul (
        .clk      (clk),
        .rst      (rst),
        .in_fire  (in_fire),
        .in_last  (in_last),
        .in_a     (in_a),
        .in_b     (in_b),
        .out_vld  (mul_vld),
        .out_last (mul_last),
        .out_prod (mul_prod)
    );

    dp_add_ring #(
        .ACC_W (ACC_W),
        .SLOTS (ADD_STAGES)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .clr        (phase_q == PH_PAIR),
        .add_vld    (mul_vld),
        .add_val    (mul_prod),
        .slots_flat (ring_flat)
    );

    dp_fold #(
        .ACC_W (ACC_W),
        .SLOTS (ADD_STAGES)
    ) u_fold (
        .clk        (clk),
        .rst        (rst),
        .cap_pairs  (phase_q == PH_PAIR),
        .cap_final  (phase_q == PH_FINAL),
        .slots_flat (ring_flat),
        .result     (out_sum)
    );

    // Phase sequencing: accept -> flush multiplier -> pair fold -> final fold.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ACCEPT;
            done_q  <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_FINAL);
            unique case (phase_q)
                PH_ACCEPT: if (in_fire && in_last)  phase_q <= PH_FLUSH;
                PH_FLUSH:  if (mul_vld && mul_last) phase_q <= PH_PAIR;
                PH_PAIR:   phase_q <= PH_FINAL;
                PH_FINAL:  phase_q <= PH_ACCEPT;
                default:   phase_q <= PH_ACCEPT;
            endcase
        end
    end

    assign out_done = done_q;

endmodule

// File: rtl/dp_inner_product_chk.sv
module dp_inner_product_chk #(
    parameter int ACC_W = 24,
    parameter int SLOTS = 4,
    parameter int LAT   = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   in_last,
    input logic                   busy,
    input logic                   out_done,
    input logic [ACC_W-1:0]       out_sum,
    input logic [SLOTS*ACC_W-1:0] ring_flat
);
    localparam int CNT_W = $clog2(LAT + 3) + 1;

    logic [CNT_W-1:0] since_last;

    // Edges counted from the edge that accepted the last element.
    always_ff @(posedge clk) begin
        if (rst) begin
            since_last <= '0;
        end else if (in_valid && in_last && !busy) begin
            since_last <= CNT_W'(1);
        end else if (out_done) begin
            since_last <= '0;
        end else if (since_last != '0) begin
            since_last <= since_last + CNT_W'(1);
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    // R2
    sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> $stable(out_sum));

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (since_last == CNT_W'(LAT + 1)));

    // R3
    no_late_done_chk: assert property (@(posedge clk) disable iff (rst)
        since_last <= CNT_W'(LAT + 1));

    // R4
    ring_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (ring_flat == '0));

endmodule

bind dp_inner_product dp_inner_product_chk #(
    .ACC_W (ACC_W),
    .SLOTS (ADD_STAGES),
    .LAT   (MUL_STAGES + 2)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .busy      (busy),
    .out_done  (out_done),
    .out_sum   (out_sum),
    .ring_flat (ring_flat)
);

// File: tb/dp_inner_product_tb.sv
module dp_inner_product_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int AW   = 24;
    localparam int LAT  = 6;
    localparam int MAXL = 64;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic [DW-1:0] in_a = '0;
    logic [DW-1:0] in_b = '0;
    logic          out_done;
    logic [AW-1:0] out_sum;

    logic [DW-1:0] va [MAXL];
    logic [DW-1:0] vb [MAXL];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_inner_product u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_a     (in_a),
        .in_b     (in_b),
        .out_done (out_done),
        .out_sum  (out_sum)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] dot(input int len);
        logic [AW-1:0] acc = '0;
        for (int i = 0; i < len; i++) begin
            logic signed [2*DW-1:0] p;
            p   = $signed(va[i]) * $signed(vb[i]);
            acc = acc + {{(AW-2*DW){p[2*DW-1]}}, p};
        end
        return acc;
    endfunction

    task automatic fill_rand(input int len);
        for (int i = 0; i < len; i++) begin
            va[i] = DW'($urandom);
            vb[i] = DW'($urandom);
        end
    endtask

    // Entered and left at a falling edge.
    task automatic run_vec(input int len, input int gap_pct, input bit junk,
                           input bit hold, input string req);
        logic [AW-1:0] exp;
        bit lat_ok;
        exp = dot(len);
        for (int i = 0; i < len; i++) begin
            while (int'($urandom_range(99)) < gap_pct) begin
                in_valid = 1'b0;
                in_last  = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_a     = va[i];
            in_b     = vb[i];
            in_last  = (i == len - 1);
            if (i != len - 1) @(negedge clk);
        end
        lat_ok = 1'b1;
        for (int k = 1; k <= LAT + 1; k++) begin
            @(negedge clk);
            if (out_done != (k == LAT + 1)) lat_ok = 1'b0;
            if (k <= LAT) begin
                in_valid = junk;
                in_last  = junk ? 1'($urandom) : 1'b0;
                in_a     = DW'($urandom);
                in_b     = DW'($urandom);
            end
        end
        check(lat_ok, "R3", "done timing", longint'(out_done), 1);
        check(out_sum == exp, req, "result", longint'(out_sum), longint'(exp));
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (hold) begin
            @(negedge clk);
            check(out_done == 1'b0, "R2", "done pulse width", longint'(out_done), 0);
            check(out_sum == exp, "R2", "result held", longint'(out_sum), longint'(exp));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(out_done == 1'b0, "R8", "done after reset", longint'(out_done), 0);
        check(out_sum == '0, "R8", "sum after reset", longint'(out_sum), 0);

        // R1 directed: (1..4).(5..8) = 70
        for (int i = 0; i < 4; i++) begin
            va[i] = DW'(i + 1);
            vb[i] = DW'(i + 5);
        end
        run_vec(4, 0, 0, 1, "R1");
        check(out_sum == AW'(70), "R1", "known dot", longint'(out_sum), 70);

        // R1 signed: eight elements with mixed signs
        for (int i = 0; i < 8; i++) begin
            va[i] = DW'(i - 4);
            vb[i] = DW'(3);
        end
        run_vec(8, 0, 0, 1, "R1");

        // R5 lengths not a multiple of four
        run_vec(1, 0, 0, 0, "R5");
        fill_rand(2); run_vec(2, 0, 0, 0, "R5");
        fill_rand(3); run_vec(3, 0, 0, 0, "R5");
        fill_rand(5); run_vec(5, 0, 0, 1, "R5");
        fill_rand(7); run_vec(7, 0, 0, 0, "R5");

        // R6 idle gaps inside a vector
        fill_rand(12); run_vec(12, 40, 0, 1, "R6");

        // R4 big negative vector followed by all-zero vector
        for (int i = 0; i < 16; i++) begin
            va[i] = 8'h80;
            vb[i] = 8'h80;
        end
        run_vec(16, 0, 0, 1, "R1");
        for (int i = 0; i < 4; i++) begin
            va[i] = '0;
            vb[i] = '0;
        end
        run_vec(4, 0, 0, 1, "R4");

        // R7 junk during drain, then next vector starts in the done cycle
        fill_rand(6); run_vec(6, 0, 1, 0, "R7");
        fill_rand(3); run_vec(3, 0, 0, 1, "R7");

        // R1/R4 random back-to-back vectors
        for (int t = 0; t < 20; t++) begin
            int len;
            len = int'($urandom_range(MAXL - 1)) + 1;
            fill_rand(len);
            run_vec(len, 20, t[0], t[1], "R1");
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule